// File: doc/BRIEF.md
# DDR SDRAM command legality monitor

This block watches the command bus of a DDR SDRAM from the controller side. It follows one chosen bank and the device-wide busy periods that a refresh or a mode-register write causes. Every clock it decodes the command from the active-low chip-select, row-strobe, column-strobe and write-enable lines, together with the bank field and the auto-precharge address bit. When that command is not permitted in the present state, it raises a flag in the same cycle.

The tracked bank has two stable states, idle and row-active. It also has four transient states: write recovery, write recovery followed by precharge, refreshing, and mode-register access. The command that starts a transient state also fixes the state it leaves to. A down-counter loads the matching interval (write recovery, row cycle or mode-register delay) from an input on entry, and the state is left when that interval runs out.

Clock-enable is taken to be high in the previous and the current cycle. Data-path timing, bus turn-around, burst interruption and power-down are outside the block.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: Commands are decoded from {cs_n,ras_n,cas_n,we_n} as follows: cs_n=1 is deselect; 0111 is no-operation; 0110 is burst terminate; 0101 is read; 0100 is write; 0011 is activate; 0010 is precharge; 0001 is refresh; 0000 is mode-register set. Deselect, whatever the other strobes are, and no-operation are never flagged.
- R2: bank_state reports 0=idle, 1=row-active, 2=write recovery, 3=write recovery with precharge, 4=refreshing and 5=mode-register access. After reset it reads idle and illegal is low.
- R3: In idle, a read or write to the tracked bank is illegal, and the same command to another bank is legal. An activate to the tracked bank moves the state to row-active.
- R4: In row-active, an activate to the tracked bank, a refresh or a mode-register set is illegal, and a read is legal and keeps the state. A precharge to the tracked bank, or any precharge with ap_flag=1 (precharge-all), moves the state to idle. A write to the tracked bank moves the state to write recovery when ap_flag=0 and to write recovery with precharge when ap_flag=1.
- R5: Write recovery lasts max(wr_cycles,1) clock cycles after the edge that samples the write, and then returns to row-active.
- R6: Write recovery with precharge lasts max(wr_cycles,1) cycles and then goes to idle.
- R7: A refresh in idle enters refreshing, which lasts max(rc_cycles,1) cycles and then goes to idle.
- R8: A mode-register set in idle enters mode-register access, which lasts max(mrd_cycles,1) cycles and then goes to idle.
- R9: In every transient state, burst terminate, refresh and mode-register set are illegal.
- R10: In both write-recovery states, a read, write, activate or precharge to the tracked bank is illegal, and so is a precharge with ap_flag=1. The same commands to another bank, with ap_flag=0 for precharge, are legal.
- R11: In refreshing and mode-register access, every command other than deselect and no-operation is illegal, whatever the bank.
- R12: illegal is high during the cycle in which the offending command is on the bus. An illegal command causes no state change. A transient state's interval keeps running through illegal commands.
- R13: The interval is captured when a transient state is entered. Changing the cycle-count input afterwards does not change how long that state lasts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| bank | input | BANK_W | Bank field of the command |
| ap_flag | input | 1 | Auto-precharge / precharge-all address bit |
| wr_cycles | input | CNT_W | Write-recovery interval in cycles |
| rc_cycles | input | CNT_W | Row-cycle interval in cycles |
| mrd_cycles | input | CNT_W | Mode-register-set delay in cycles |
| illegal | output | 1 | High in the cycle an illegal command is on the bus |
| bank_state | output | 3 | Tracked state, encoded as in R2 |

## Verification
The hardest case to reach is a transient state whose timer runs out while illegal commands keep arriving. In that case the flag must fire, the state must not change early, and the exit must still happen on the edge set by the interval captured at entry. The stimulus opens a six-cycle write recovery and lowers the write-recovery input right after entry. It then fills the interval with illegal reads, activates and precharges to the busy bank, together with a legal precharge to another bank, and expects row-active on exactly the seventh cycle. Refresh and mode-register periods are also filled with commands to other banks, which must all be flagged because the device is busy.

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor #(
  parameter int BANK_W     = 2,
  parameter int TRACK_BANK = 0,
  parameter int CNT_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [BANK_W-1:0] bank,
  input  logic              ap_flag,
  input  logic [CNT_W-1:0]  wr_cycles,
  input  logic [CNT_W-1:0]  rc_cycles,
  input  logic [CNT_W-1:0]  mrd_cycles,
  output logic              illegal,
  output logic [2:0]        bank_state
);
  localparam logic [2:0] ST_IDLE = 3'd0;
  localparam logic [2:0] ST_ACT  = 3'd1;
  localparam logic [2:0] ST_WR   = 3'd2;
  localparam logic [2:0] ST_WRAP = 3'd3;
  localparam logic [2:0] ST_REF  = 3'd4;
  localparam logic [2:0] ST_MODE = 3'd5;
  localparam logic [BANK_W-1:0] TB = BANK_W'(TRACK_BANK);
  localparam logic [CNT_W-1:0]  ONE = CNT_W'(1);

  logic [2:0]       st;
  logic [CNT_W-1:0] cnt;
  logic             ill;

  wire sel    = ~cs_n;
  wire c_nop  = sel &  ras_n &  cas_n &  we_n;
  wire c_bst  = sel &  ras_n &  cas_n & ~we_n;
  wire c_rd   = sel &  ras_n & ~cas_n &  we_n;
  wire c_wr   = sel &  ras_n & ~cas_n & ~we_n;
  wire c_act  = sel & ~ras_n &  cas_n &  we_n;
  wire c_pre  = sel & ~ras_n &  cas_n & ~we_n;
  wire c_ref  = sel & ~ras_n & ~cas_n &  we_n;
  wire c_mrs  = sel & ~ras_n & ~cas_n & ~we_n;
  wire hit    = (bank == TB);
  wire pre_on = c_pre & (hit | ap_flag);

  always_comb begin
    case (st)
      ST_IDLE:      ill = (c_rd | c_wr) & hit;
      ST_ACT:       ill = (c_act & hit) | c_ref | c_mrs;
      ST_WR,
      ST_WRAP:      ill = c_bst | c_ref | c_mrs | ((c_rd | c_wr | c_act) & hit) | pre_on;
      default:      ill = sel & ~c_nop;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= ST_IDLE;
      cnt <= '0;
    end else begin
      case (st)
        ST_IDLE: if (!ill) begin
          if (c_act && hit) st <= ST_ACT;
          else if (c_ref) begin
            st  <= ST_REF;
            cnt <= rc_cycles;
          end else if (c_mrs) begin
            st  <= ST_MODE;
            cnt <= mrd_cycles;
          end
        end
        ST_ACT: if (!ill) begin
          if (c_wr && hit) begin
            st  <= ap_flag ? ST_WRAP : ST_WR;
            cnt <= wr_cycles;
          end else if (pre_on) st <= ST_IDLE;
        end
        ST_WR, ST_WRAP, ST_REF, ST_MODE: begin
          if (cnt <= ONE) st <= (st == ST_WR) ? ST_ACT : ST_IDLE;
          else            cnt <= cnt - ONE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign illegal    = ill;
  assign bank_state = st;
endmodule

// File: rtl/sdram_cmd_monitor_chk.sv
module sdram_cmd_monitor_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       ras_n,
  input logic       cas_n,
  input logic       we_n,
  input logic       illegal,
  input logic [2:0] bank_state
);
  wire nop    = !cs_n && ras_n && cas_n && we_n;
  wire bst    = !cs_n && ras_n && cas_n && !we_n;
  wire trans  = bank_state >= 3'd2 && bank_state <= 3'd5;
  wire devbsy = bank_state == 3'd4 || bank_state == 3'd5;

  assert_deselect_ok_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !illegal);
  assert_nop_ok_R1: assert property (@(posedge clk) disable iff (!rst_n)
    nop |-> !illegal);
  assert_wr_exit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bank_state == 3'd2 |=> (bank_state == 3'd2 || bank_state == 3'd1));
  assert_wrap_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bank_state == 3'd3 |=> (bank_state == 3'd3 || bank_state == 3'd0));
  assert_ref_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bank_state == 3'd4 |=> (bank_state == 3'd4 || bank_state == 3'd0));
  assert_mode_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bank_state == 3'd5 |=> (bank_state == 3'd5 || bank_state == 3'd0));
  assert_bst_reject_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (trans && bst) |-> illegal);
  assert_busy_reject_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (devbsy && !cs_n && !nop) |-> illegal);
  assert_hold_state_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (illegal && bank_state <= 3'd1) |=> $stable(bank_state));
endmodule

bind sdram_cmd_monitor sdram_cmd_monitor_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
  .we_n(we_n), .illegal(illegal), .bank_state(bank_state)
);

// File: tb/sdram_cmd_monitor_test.sv
module sdram_cmd_monitor_test;
  localparam logic [3:0] DSL = 4'b1111, NOP = 4'b0111, BST = 4'b0110, RD = 4'b0101,
                         WR = 4'b0100, ACT = 4'b0011, PRE = 4'b0010, REF = 4'b0001,
                         MRS = 4'b0000;
  localparam logic [2:0] S_IDLE = 0, S_ACT = 1, S_WR = 2, S_WRAP = 3, S_REF = 4, S_MODE = 5;

  typedef struct { logic ill; logic [2:0] st; string req; } exp_t;

  logic clk = 0, rst_n = 0;
  logic cs_n = 1, ras_n = 1, cas_n = 1, we_n = 1, ap_flag = 0;
  logic [1:0] bank = 0;
  logic [7:0] wr_cycles = 3, rc_cycles = 4, mrd_cycles = 2;
  logic illegal;
  logic [2:0] bank_state;
  exp_t q[$];
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sdram_cmd_monitor uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .bank(bank), .ap_flag(ap_flag), .wr_cycles(wr_cycles), .rc_cycles(rc_cycles),
    .mrd_cycles(mrd_cycles), .illegal(illegal), .bank_state(bank_state)
  );

  task automatic cyc(input logic [3:0] c, input logic [1:0] b, input logic ap,
                     input logic e_ill, input logic [2:0] e_st, input string req);
    exp_t it;
    @(posedge clk); #1;
    {cs_n, ras_n, cas_n, we_n} = c;
    bank = b;
    ap_flag = ap;
    it.ill = e_ill; it.st = e_st; it.req = req;
    q.push_back(it);
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t it;
      it = q.pop_front();
      checks += 2;
      if (illegal !== it.ill) begin
        errors++;
        $display("FAIL %s: illegal=%0b expected %0b", it.req, illegal, it.ill);
      end
      if (bank_state !== it.st) begin
        errors++;
        $display("FAIL %s: bank_state=%0d expected %0d", it.req, bank_state, it.st);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    cyc(DSL, 0, 0, 0, S_IDLE, "R2");
    cyc(RD,  0, 0, 1, S_IDLE, "R3");
    cyc(WR,  0, 0, 1, S_IDLE, "R3");
    cyc(RD,  1, 0, 0, S_IDLE, "R3");
    cyc(ACT, 0, 0, 0, S_IDLE, "R3");
    cyc(ACT, 0, 0, 1, S_ACT,  "R4");
    cyc(REF, 0, 0, 1, S_ACT,  "R4");
    cyc(MRS, 0, 0, 1, S_ACT,  "R12");
    cyc(RD,  0, 0, 0, S_ACT,  "R4");
    cyc(WR,  0, 0, 0, S_ACT,  "R4");
    cyc(BST, 0, 0, 1, S_WR,   "R9");
    cyc(WR,  1, 0, 0, S_WR,   "R10");
    cyc(NOP, 0, 0, 0, S_WR,   "R5");
    cyc(NOP, 0, 0, 0, S_ACT,  "R5");
    wr_cycles = 6;
    cyc(WR,  0, 0, 0, S_ACT,  "R4");
    cyc(RD,  0, 0, 1, S_WR,   "R10");
    wr_cycles = 1;
    cyc(ACT, 0, 0, 1, S_WR,   "R10");
    cyc(PRE, 0, 0, 1, S_WR,   "R10");
    cyc(PRE, 2, 1, 1, S_WR,   "R10");
    cyc(REF, 0, 0, 1, S_WR,   "R12");
    cyc(PRE, 3, 0, 0, S_WR,   "R10");
    cyc(NOP, 0, 0, 0, S_ACT,  "R13");
    wr_cycles = 2;
    cyc(WR,  0, 1, 0, S_ACT,  "R4");
    cyc(MRS, 0, 0, 1, S_WRAP, "R9");
    cyc(DSL, 0, 0, 0, S_WRAP, "R6");
    cyc(NOP, 0, 0, 0, S_IDLE, "R6");
    cyc(ACT, 0, 0, 0, S_IDLE, "R3");
    cyc(PRE, 1, 0, 0, S_ACT,  "R4");
    cyc(PRE, 1, 1, 0, S_ACT,  "R4");
    cyc(NOP, 0, 0, 0, S_IDLE, "R4");
    cyc(REF, 0, 0, 0, S_IDLE, "R7");
    cyc(RD,  1, 0, 1, S_REF,  "R11");
    cyc(ACT, 2, 0, 1, S_REF,  "R11");
    cyc(BST, 0, 0, 1, S_REF,  "R9");
    cyc(4'b1000, 0, 0, 0, S_REF, "R1");
    cyc(NOP, 0, 0, 0, S_IDLE, "R7");
    mrd_cycles = 0;
    cyc(MRS, 0, 0, 0, S_IDLE, "R8");
    cyc(REF, 0, 0, 1, S_MODE, "R11");
    cyc(NOP, 0, 0, 0, S_IDLE, "R8");
    mrd_cycles = 2;
    cyc(MRS, 0, 0, 0, S_IDLE, "R8");
    cyc(WR,  3, 0, 1, S_MODE, "R11");
    cyc(NOP, 0, 0, 0, S_MODE, "R1");
    cyc(NOP, 0, 0, 0, S_IDLE, "R8");
    repeat (2) @(posedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: done=0 expected 1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule